// File: doc/BRIEF.md
# Console Bus Memory Router

This block sits between the CPU of an 8-bit handheld console and its memories. It takes the 16-bit CPU address and decides which memory region the access belongs to. Accesses to the cartridge windows and to the I/O window are sent out on separate ports, each with its own read and write strobes. Video RAM, two work-RAM banks, the sprite attribute table and high RAM are stored inside the block. The block also folds the echo window back onto work RAM.

A read is single-cycle and registered. The CPU raises `cpu_rd` with an address, and the byte appears on `cpu_rdata` in the next cycle. This holds whether the byte comes from an internal array, the cartridge port or the I/O port. The external agents are expected to register their data on the same edge that samples the strobe. Writes take effect on the clock edge. Bank switching in the cartridge and the I/O register contents are handled outside this block.

Top module: `console_mem_router`

## Requirements
- R1: An access to 0x0000–0x7FFF (both ROM windows) raises only `cart_rd` or `cart_wr`. `cart_addr` equals `cpu_addr`. The byte the cartridge returns one cycle later appears on `cpu_rdata`.
- R2: An access to 0x A000–0xBFFF (external RAM window) is forwarded to the cartridge port in the same way as R1. A cartridge write carries `cpu_wdata` on `cart_wdata`.
- R3: 0x8000–0x9FFF is an internal 8 KiB video RAM. A byte written there reads back unchanged, and no cartridge or I/O strobe rises.
- R4: 0xC000–0xCFFF and 0xD000–0xDFFF are two separate internal 4 KiB work-RAM banks. The same offset in the two banks holds independent bytes.
- R5: Any address in 0xE000–0xFDFF reads and writes the work-RAM byte at that address minus 0x2000. This holds in both directions.
- R6: 0xFE00–0xFE9F is an internal 160-byte sprite attribute table.
- R7: In 0xFEA0–0xFEFF, reads return 0xFF. Writes raise no strobe and change no stored byte.
- R8: 0xFF00–0xFF7F and 0xFFFF go to the I/O port. `io_addr` is the low address byte, and `io_rdata` returns one cycle later on `cpu_rdata`. No other strobe rises.
- R9: 0xFF80–0xFFFE is internal high RAM, with every byte of the window usable.
- R10: Read data is valid exactly in the cycle after `cpu_rd`. Back-to-back reads to different regions each return their own byte.
- R11: After reset, and at all times, at most one target (cartridge, I/O or an internal array) is strobed per cycle. `cpu_rdata` reads 0xFF after reset, before any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| cart_addr | output | 16 | Cartridge address |
| cart_wdata | output | 8 | Cartridge write data |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_rdata | input | 8 | Cartridge read data, registered by the cartridge |
| io_addr | output | 8 | I/O register index (low address byte) |
| io_wdata | output | 8 | I/O write data |
| io_wr | output | 1 | I/O write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_rdata | input | 8 | I/O read data, registered by the I/O agent |

## Verification
The bench probes every region edge, where a wrong comparison would send the boundary byte to a neighbouring region:
- 0x7FFF/0x8000, 0x9FFF/0xA000 and 0xBFFF/0xC000.
- 0xCFFF/0xD000.
- 0xFDFF/0xFE00, 0xFE9F/0xFEA0 and 0xFEFF/0xFF00.
- 0xFF7F/0xFF80 and 0xFFFE/0xFFFF.

Echo addresses are written and read from both sides. A wrong alias offset or bank bit would show up as a stale byte. The same offset is used in the two work-RAM banks, so a missing bank bit would overwrite the other bank. Writes into the unusable hole are followed by reads of the hole and of the sprite table next to it, and the external write counters are checked. Back-to-back reads across internal, cartridge, I/O and hole regions would expose a mux that follows the current address instead of the registered one.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  localparam int BUS_AW  = 16;
  localparam int OFS_W   = 13;

  localparam logic [15:0] ECHO_LAST   = 16'hFDFF;
  localparam logic [15:0] SPRITE_LAST = 16'hFE9F;
  localparam logic [15:0] HOLE_LAST   = 16'hFEFF;
  localparam logic [15:0] IO_ENABLE   = 16'hFFFF;

  typedef enum logic [2:0] {
    RG_CART, RG_VRAM, RG_WRAM0, RG_WRAM1,
    RG_SPRT, RG_HOLE, RG_IO, RG_HRAM
  } region_e;

  typedef struct packed {
    region_e          rgn;
    logic [OFS_W-1:0] ofs;
  } route_t;

  // Map a bus address to a region and an offset inside that region.
  function automatic route_t route_addr(input logic [BUS_AW-1:0] a);
    route_t r;
    r.rgn = RG_HOLE;
    r.ofs = a[OFS_W-1:0];
    if (!a[15]) begin
      r.rgn = RG_CART;
    end else begin
      unique case (a[15:13])
        3'b100: r.rgn = RG_VRAM;
        3'b101: r.rgn = RG_CART;
        3'b110: r.rgn = a[12] ? RG_WRAM1 : RG_WRAM0;
        default: begin
          if (a <= ECHO_LAST) begin
            // echo: bits 12..0 already equal those of address - 0x2000
            r.rgn = a[12] ? RG_WRAM1 : RG_WRAM0;
          end else if (a <= SPRITE_LAST) begin
            r.rgn = RG_SPRT;
            r.ofs = {5'd0, a[7:0]};
          end else if (a <= HOLE_LAST) begin
            r.rgn = RG_HOLE;
          end else if (a == IO_ENABLE || !a[7]) begin
            r.rgn = RG_IO;
            r.ofs = {5'd0, a[7:0]};
          end else begin
            r.rgn = RG_HRAM;
            r.ofs = {6'd0, a[6:0]};
          end
        end
      endcase
    end
    if (r.rgn == RG_WRAM0 || r.rgn == RG_WRAM1) r.ofs = {1'b0, a[11:0]};
    return r;
  endfunction

endpackage

// File: rtl/mem_route_decode.sv
module mem_route_decode
  import mmap_pkg::*;
(
  input  logic [BUS_AW-1:0] addr,
  output route_t            route
);

  assign route = route_addr(addr);

endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[addr];
  end

  // R10
  wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !we && $past(we) && addr == $past(addr)) |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/console_mem_router.sv
module console_mem_router
  import mmap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int VRAM_BYTES  = 8192,
  parameter int VRAM_SLICE  = 4096,
  parameter int WRAM_BYTES  = 4096,
  parameter int SPRT_BYTES  = 160,
  parameter int HRAM_BYTES  = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [15:0]       cart_addr,
  output logic [DATA_W-1:0] cart_wdata,
  output logic              cart_wr,
  output logic              cart_rd,
  input  logic [DATA_W-1:0] cart_rdata,
  output logic [7:0]        io_addr,
  output logic [DATA_W-1:0] io_wdata,
  output logic              io_wr,
  output logic              io_rd,
  input  logic [DATA_W-1:0] io_rdata
);

  localparam int VSL      = VRAM_BYTES / VRAM_SLICE;
  localparam int VSL_W    = (VSL > 1) ? $clog2(VSL) : 1;
  localparam int SLICE_AW = $clog2(VRAM_SLICE);
  localparam int WRAM_AW  = $clog2(WRAM_BYTES);
  localparam int SPRT_AW  = $clog2(SPRT_BYTES);
  localparam int HRAM_AW  = $clog2(HRAM_BYTES);
  localparam int WBANKS   = 2;
  localparam logic [DATA_W-1:0] OPEN_BUS = '1;

  route_t rt;
  mem_route_decode u_dec (.addr(cpu_addr), .route(rt));

  // named events for the assertions
  logic cart_hit, io_hit, hole_hit, vram_hit, sprt_hit, hram_hit;
  assign cart_hit = (rt.rgn == RG_CART);
  assign io_hit   = (rt.rgn == RG_IO);
  assign hole_hit = (rt.rgn == RG_HOLE);
  assign vram_hit = (rt.rgn == RG_VRAM);
  assign sprt_hit = (rt.rgn == RG_SPRT);
  assign hram_hit = (rt.rgn == RG_HRAM);

  logic [VSL_W-1:0] vsl_idx;
  assign vsl_idx = VSL_W'(rt.ofs >> SLICE_AW);

  // external ports
  assign cart_addr  = cpu_addr;
  assign cart_wdata = cpu_wdata;
  assign cart_wr    = cpu_wr & cart_hit;
  assign cart_rd    = cpu_rd & cart_hit;
  assign io_addr    = cpu_addr[7:0];
  assign io_wdata   = cpu_wdata;
  assign io_wr      = cpu_wr & io_hit;
  assign io_rd      = cpu_rd & io_hit;

  // video RAM, split into slices
  logic [DATA_W-1:0] vram_q [VSL];
  logic [VSL-1:0]    vram_we;
  for (genvar s = 0; s < VSL; s++) begin : g_vram
    logic sel;
    assign sel        = vram_hit && (vsl_idx == VSL_W'(s));
    assign vram_we[s] = sel & cpu_wr;
    byte_ram #(.DEPTH(VRAM_SLICE), .DW(DATA_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(vram_we[s]), .re(sel & cpu_rd),
      .addr(SLICE_AW'(rt.ofs)), .wdata(cpu_wdata), .rdata(vram_q[s]));
  end

  // work RAM banks (echo folds onto these through the decoder)
  logic [DATA_W-1:0] wram_q [WBANKS];
  logic [WBANKS-1:0] wram_we;
  for (genvar b = 0; b < WBANKS; b++) begin : g_wram
    logic sel;
    assign sel        = (rt.rgn == ((b == 0) ? RG_WRAM0 : RG_WRAM1));
    assign wram_we[b] = sel & cpu_wr;
    byte_ram #(.DEPTH(WRAM_BYTES), .DW(DATA_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(wram_we[b]), .re(sel & cpu_rd),
      .addr(WRAM_AW'(rt.ofs)), .wdata(cpu_wdata), .rdata(wram_q[b]));
  end

  logic [DATA_W-1:0] sprt_q, hram_q;
  logic              sprt_we, hram_we;
  assign sprt_we = sprt_hit & cpu_wr;
  assign hram_we = hram_hit & cpu_wr;

  byte_ram #(.DEPTH(SPRT_BYTES), .DW(DATA_W)) u_sprt (
    .clk(clk), .rst_n(rst_n), .we(sprt_we), .re(sprt_hit & cpu_rd),
    .addr(SPRT_AW'(rt.ofs)), .wdata(cpu_wdata), .rdata(sprt_q));

  byte_ram #(.DEPTH(HRAM_BYTES), .DW(DATA_W)) u_hram (
    .clk(clk), .rst_n(rst_n), .we(hram_we), .re(hram_hit & cpu_rd),
    .addr(HRAM_AW'(rt.ofs)), .wdata(cpu_wdata), .rdata(hram_q));

  logic int_we;
  assign int_we = (|vram_we) | (|wram_we) | sprt_we | hram_we;

  // registered read steering
  region_e          rgn_q;
  logic [VSL_W-1:0] vsl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn_q <= RG_HOLE;
      vsl_q <= '0;
    end else if (cpu_rd) begin
      rgn_q <= rt.rgn;
      vsl_q <= vsl_idx;
    end
  end

  always_comb begin
    unique case (rgn_q)
      RG_CART:  cpu_rdata = cart_rdata;
      RG_IO:    cpu_rdata = io_rdata;
      RG_VRAM:  cpu_rdata = vram_q[vsl_q];
      RG_WRAM0: cpu_rdata = wram_q[0];
      RG_WRAM1: cpu_rdata = wram_q[1];
      RG_SPRT:  cpu_rdata = sprt_q;
      RG_HRAM:  cpu_rdata = hram_q;
      default:  cpu_rdata = OPEN_BUS;
    endcase
  end

  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cart_wr, io_wr, int_we}));

  // R1
  cart_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_rd || cart_wr) |-> (!cpu_addr[15] || cpu_addr[15:13] == 3'b101));

  // R8
  io_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> (cpu_addr[15:8] == 8'hFF && (!cpu_addr[7] || &cpu_addr[6:0])));

  // R7
  hole_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr >= 16'hFEA0 && cpu_addr <= 16'hFEFF) |=> (cpu_rdata == 8'hFF));

  // R5
  echo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr >= 16'hE000 && cpu_addr <= 16'hFDFF) |-> (|wram_we));

endmodule

// File: tb/console_mem_router_tb_top.sv
module console_mem_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [15:0] cart_addr;
  logic [7:0]  cart_wdata, cart_rdata;
  logic        cart_wr, cart_rd;
  logic [7:0]  io_addr, io_wdata, io_rdata;
  logic        io_wr, io_rd;

  always #10 clk = ~clk;  // 50 MHz

  console_mem_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata),
    .cart_addr(cart_addr), .cart_wdata(cart_wdata), .cart_wr(cart_wr), .cart_rd(cart_rd),
    .cart_rdata(cart_rdata),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata));

  // external agent models: registered read data
  function automatic logic [7:0] cart_pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] io_pat(input logic [7:0] a);
    return a ^ 8'hC3;
  endfunction

  int          cw_cnt = 0, iw_cnt = 0;
  logic [15:0] cw_addr = '0;
  logic [7:0]  cw_data = '0, iw_addr = '0, iw_data = '0;
  always @(posedge clk) begin
    if (cart_rd) cart_rdata <= cart_pat(cart_addr);
    if (io_rd)   io_rdata   <= io_pat(io_addr);
    if (cart_wr) begin cw_cnt <= cw_cnt + 1; cw_addr <= cart_addr; cw_data <= cart_wdata; end
    if (io_wr)   begin iw_cnt <= iw_cnt + 1; iw_addr <= io_addr;   iw_data <= io_wdata;   end
  end

  int vectors = 0, miscompares = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobes seen before the edge: {cart_rd,cart_wr,io_rd,io_wr}
  task automatic wr(input logic [15:0] a, input logic [7:0] d, output logic [3:0] stb);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1 stb = {cart_rd, cart_wr, io_rd, io_wr};
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic [3:0] stb);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1 stb = {cart_rd, cart_wr, io_rd, io_wr};
    @(posedge clk);
    #1 d = cpu_rdata;
    cpu_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 rdata after reset", {8'h0, cpu_rdata}, 16'h00FF);
    chk("R11 no strobes idle", {12'h0, cart_rd, cart_wr, io_rd, io_wr}, 16'h0);
  endtask

  task automatic t_cart();
    logic [7:0] d; logic [3:0] s;
    logic [15:0] addrs [5] = '{16'h0123, 16'h3FFF, 16'h4ABC, 16'h7FFF, 16'hA000};
    foreach (addrs[i]) begin
      rd(addrs[i], d, s);
      chk("R1 cart read strobe", {12'h0, s}, 16'h8);
      chk("R1 cart read data", {8'h0, d}, {8'h0, cart_pat(addrs[i])});
    end
    rd(16'hBFFF, d, s);
    chk("R2 ext ram read strobe", {12'h0, s}, 16'h8);
    chk("R2 ext ram read data", {8'h0, d}, {8'h0, cart_pat(16'hBFFF)});
    wr(16'hB123, 8'h3C, s);
    chk("R2 ext ram write strobe", {12'h0, s}, 16'h4);
    chk("R2 cart write addr", cw_addr, 16'hB123);
    chk("R2 cart write data", {8'h0, cw_data}, 16'h003C);
    wr(16'h2000, 8'h0A, s);
    chk("R1 rom window write", cw_addr, 16'h2000);
  endtask

  task automatic t_vram();
    logic [7:0] d; logic [3:0] s;
    wr(16'h8000, 8'h11, s); chk("R3 vram write no ext strobe", {12'h0, s}, 16'h0);
    wr(16'h8FFF, 8'h33, s);
    wr(16'h9000, 8'h44, s);
    wr(16'h9FFF, 8'h22, s);
    rd(16'h8000, d, s); chk("R3 vram 8000", {8'h0, d}, 16'h11);
    chk("R3 vram read no ext strobe", {12'h0, s}, 16'h0);
    rd(16'h8FFF, d, s); chk("R3 vram 8FFF", {8'h0, d}, 16'h33);
    rd(16'h9000, d, s); chk("R3 vram 9000", {8'h0, d}, 16'h44);
    rd(16'h9FFF, d, s); chk("R3 vram 9FFF", {8'h0, d}, 16'h22);
  endtask

  task automatic t_wram();
    logic [7:0] d; logic [3:0] s;
    wr(16'hC000, 8'hA1, s);
    wr(16'hD000, 8'hB2, s);
    wr(16'hCFFF, 8'hC3, s);
    wr(16'hDFFF, 8'hD4, s);
    rd(16'hC000, d, s); chk("R4 wram0 C000", {8'h0, d}, 16'hA1);
    rd(16'hD000, d, s); chk("R4 wram1 D000", {8'h0, d}, 16'hB2);
    rd(16'hCFFF, d, s); chk("R4 wram0 CFFF", {8'h0, d}, 16'hC3);
    rd(16'hDFFF, d, s); chk("R4 wram1 DFFF", {8'h0, d}, 16'hD4);
  endtask

  task automatic t_echo();
    logic [7:0] d; logic [3:0] s;
    wr(16'hE005, 8'h77, s);
    chk("R5 echo write no ext strobe", {12'h0, s}, 16'h0);
    rd(16'hC005, d, s); chk("R5 echo write lands C005", {8'h0, d}, 16'h77);
    wr(16'hD123, 8'h5E, s);
    rd(16'hF123, d, s); chk("R5 echo read F123", {8'h0, d}, 16'h5E);
    rd(16'hE000, d, s); chk("R5 echo read E000", {8'h0, d}, 16'hA1);
    wr(16'hFDFF, 8'h99, s);
    rd(16'hDDFF, d, s); chk("R5 echo top FDFF", {8'h0, d}, 16'h99);
  endtask

  task automatic t_sprite();
    logic [7:0] d; logic [3:0] s;
    wr(16'hFE00, 8'h61, s);
    wr(16'hFE9F, 8'h62, s);
    rd(16'hFE00, d, s); chk("R6 sprite FE00", {8'h0, d}, 16'h61);
    rd(16'hFE9F, d, s); chk("R6 sprite FE9F", {8'h0, d}, 16'h62);
    chk("R6 sprite no ext strobe", {12'h0, s}, 16'h0);
  endtask

  task automatic t_hole();
    logic [7:0] d; logic [3:0] s;
    int c0, i0;
    c0 = cw_cnt; i0 = iw_cnt;
    wr(16'hFEA0, 8'h12, s); chk("R7 hole write no strobe", {12'h0, s}, 16'h0);
    wr(16'hFEFF, 8'h34, s);
    rd(16'hFEA0, d, s); chk("R7 hole FEA0 reads FF", {8'h0, d}, 16'hFF);
    rd(16'hFEFF, d, s); chk("R7 hole FEFF reads FF", {8'h0, d}, 16'hFF);
    rd(16'hFE9F, d, s); chk("R7 sprite neighbour intact", {8'h0, d}, 16'h62);
    rd(16'hFF80, d, s); chk("R7 hram after hole write", {8'h0, d}, 16'h0081);
    chk("R7 no external writes", 16'(cw_cnt - c0 + iw_cnt - i0), 16'h0);
  endtask

  task automatic t_io();
    logic [7:0] d; logic [3:0] s;
    rd(16'hFF00, d, s); chk("R8 io FF00 strobe", {12'h0, s}, 16'h2);
    chk("R8 io FF00 data", {8'h0, d}, {8'h0, io_pat(8'h00)});
    rd(16'hFF7F, d, s); chk("R8 io FF7F data", {8'h0, d}, {8'h0, io_pat(8'h7F)});
    rd(16'hFFFF, d, s); chk("R8 io FFFF strobe", {12'h0, s}, 16'h2);
    chk("R8 io FFFF data", {8'h0, d}, {8'h0, io_pat(8'hFF)});
    wr(16'hFF40, 8'h91, s); chk("R8 io write strobe", {12'h0, s}, 16'h1);
    chk("R8 io write index", {8'h0, iw_addr}, 16'h40);
    chk("R8 io write data", {8'h0, iw_data}, 16'h91);
  endtask

  task automatic t_hram();
    logic [7:0] d; logic [3:0] s;
    wr(16'hFF80, 8'h81, s); chk("R9 hram write no io strobe", {12'h0, s}, 16'h0);
    wr(16'hFFFE, 8'h82, s);
    wr(16'hFFC0, 8'h83, s);
    rd(16'hFFFE, d, s); chk("R9 hram FFFE", {8'h0, d}, 16'h82);
    rd(16'hFFC0, d, s); chk("R9 hram FFC0", {8'h0, d}, 16'h83);
    rd(16'hFF80, d, s); chk("R9 hram FF80", {8'h0, d}, 16'h81);
  endtask

  task automatic t_latency();
    logic [7:0] d; logic [3:0] s;
    rd(16'h9FFF, d, s); chk("R10 b2b vram", {8'h0, d}, 16'h22);
    rd(16'h4001, d, s); chk("R10 b2b cart", {8'h0, d}, {8'h0, cart_pat(16'h4001)});
    rd(16'hFEC0, d, s); chk("R10 b2b hole", {8'h0, d}, 16'hFF);
    rd(16'hFF05, d, s); chk("R10 b2b io", {8'h0, d}, {8'h0, io_pat(8'h05)});
    rd(16'hD000, d, s); chk("R10 b2b wram1", {8'h0, d}, 16'hB2);
    rd(16'hC000, d, s); chk("R10 b2b wram0", {8'h0, d}, 16'hA1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_cart();
    t_vram();
    t_wram();
    t_echo();
    t_sprite();
    t_hram();
    t_hole();
    t_io();
    t_latency();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule